// File: doc/BRIEF.md
# Dual-Channel PWM Compare Output Unit

This block is an 8-bit timer/counter with two compare channels, A and B, each driving its own waveform pin. A 3-bit waveform mode selects how the counter runs: free-running normal mode, clear-on-compare (the counter restarts when it reaches compare A), fast PWM (a sawtooth that wraps to zero after TOP), or phase-correct PWM (a triangle that counts up to TOP and back down to zero). Each channel has a 2-bit output action code. What a code does depends on the waveform mode, on the count direction and on whether compare A sits at TOP.

The counter advances only on cycles where the `tick` clock-enable is high. A compare match is seen on a tick where the counter equals that channel's active compare value. The resulting set, clear or toggle is registered, so it shows on the pin one clock later. In the PWM modes, compare writes go into a buffer that is copied to the active register at TOP. This keeps a period glitch-free. Each pin carries either the waveform or a plain port value, and its output enable follows a per-pin direction bit.

Registers are written one at a time through a simple address/data strobe. The prescaler, interrupt logic and any asynchronous timer clocking are left to the surrounding chip.

Top module: `wavecmp_unit`

## Requirements
- R1: After reset, both `pin_out` bits and both `pin_oe` bits are 0. The counter is 0 and counting up. All registers and both waveform bits are 0.
- R2: Register map (address: field). Address 4 holds port A value in bit 0, port B value in bit 1, direction A in bit 2 and direction B in bit 3. `pin_oe[i]` equals the direction bit. `pin_out[i]` is 0 when the direction bit is clear. Otherwise it is the channel waveform when the channel is connected, and the port value when it is not. Code 00 is always unconnected.
- R3: Address 0 bits 2:0 select the waveform mode: 000 normal (TOP 255), 010 restart-on-compare (TOP = compare A), 011 fast PWM (TOP 255), 111 fast PWM (TOP = compare A), 001 phase-correct (TOP 255), 101 phase-correct (TOP = compare A). Outside phase-correct mode, a tick at TOP takes the counter to 0; other ticks increment it. In phase-correct mode the counter turns downward on a tick at TOP and upward on a tick at 0.
- R4: Address 1 holds the channel A code in bits 1:0 and the channel B code in bits 3:2. In normal and restart-on-compare modes, a match acts on the waveform as follows: code 01 toggles it, code 10 clears it and code 11 sets it.
- R5: In both fast PWM modes, code 10 sets the waveform on a tick at TOP and clears it on a match. Code 11 does the opposite. The TOP action wins when both coincide.
- R6: In both PWM modes, channel B code 01 is reserved. The channel is unconnected and the pin shows the port value.
- R7: In phase-correct mode, code 10 clears the waveform on a match while counting up and sets it on a match while counting down. Code 11 does the reverse.
- R8: In both PWM modes, channel A code 01 is unconnected when mode bit 2 is 0. When mode bit 2 is 1, it toggles on each match.
- R9: In both PWM modes, when active compare A equals TOP and channel A's code is 10 or 11, the match itself is ignored. On a tick at TOP, code 10 sets the A waveform and code 11 clears it.
- R10: Compare A is written at address 2 and compare B at address 3. In PWM modes a write goes to a buffer, and the buffer is copied to the active compare on a tick at TOP. In the other modes the active compare takes the written value on the next clock.
- R11: Waveforms and counter change only on ticks. A match action appears on the pin on the clock after the tick that saw the match.
- R12: Mode codes 100 and 110 behave as normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pin_out | output | 2 | Pin values, bit 0 channel A, bit 1 channel B |
| pin_oe | output | 2 | Pin output enables |

## Verification
A write or a tick presented at one rising edge shows its effect on the pins right after that edge. The counter, the waveform bits and the register fields are all updated by that edge, and the pin mux in front of them is combinational. The driver therefore sets inputs on the falling edge and pushes the expected pin pair that a cycle-level model predicts for the coming edge. The monitor pops and compares that pair one nanosecond after the rising edge. A few hand-computed duty counts, taken over whole periods, guard the model itself.

// File: rtl/wavecmp_pkg.sv
package wavecmp_pkg;

  typedef enum logic [1:0] {K_NORM, K_CTC, K_FAST, K_PHASE} kind_e;
  typedef enum logic [1:0] {A_HOLD, A_CLR, A_SET, A_TGL} act_e;

  // waveform mode code to counter behaviour; unlisted codes run as normal
  function automatic kind_e mode_kind(input logic [2:0] m);
    kind_e k;
    case (m)
      3'b010:         k = K_CTC;
      3'b011, 3'b111: k = K_FAST;
      3'b001, 3'b101: k = K_PHASE;
      default:        k = K_NORM;
    endcase
    return k;
  endfunction

  // TOP comes from compare A in these modes, otherwise the counter maximum
  function automatic logic mode_top_cmp(input logic [2:0] m);
    return (m == 3'b010) || (m == 3'b111) || (m == 3'b101);
  endfunction

  function automatic logic kind_pwm(input kind_e k);
    return (k == K_FAST) || (k == K_PHASE);
  endfunction

  function automatic logic chan_connected(input kind_e k, input logic [1:0] code,
                                          input logic hi_sel, input logic is_a);
    logic c;
    if (code == 2'b00)                        c = 1'b0;
    else if (kind_pwm(k) && code == 2'b01)    c = is_a & hi_sel;
    else                                      c = 1'b1;
    return c;
  endfunction

  // match and at_top are already qualified by the tick
  function automatic act_e chan_action(input kind_e k, input logic [1:0] code,
                                       input logic hi_sel, input logic is_a,
                                       input logic match, input logic at_top,
                                       input logic up, input logic eq_top);
    act_e r;
    r = A_HOLD;
    case (k)
      K_NORM, K_CTC: begin
        if (match) begin
          case (code)
            2'b01:   r = A_TGL;
            2'b10:   r = A_CLR;
            2'b11:   r = A_SET;
            default: r = A_HOLD;
          endcase
        end
      end
      K_FAST: begin
        if (code[1]) begin
          if (at_top)                           r = code[0] ? A_CLR : A_SET;
          else if (match && !(is_a && eq_top))  r = code[0] ? A_SET : A_CLR;
        end else if (code == 2'b01 && is_a && hi_sel && match) begin
          r = A_TGL;
        end
      end
      default: begin
        if (code[1]) begin
          if (is_a && eq_top) begin
            if (at_top) r = code[0] ? A_CLR : A_SET;
          end else if (match) begin
            r = (up ^ code[0]) ? A_CLR : A_SET;
          end
        end else if (code == 2'b01 && is_a && hi_sel && match) begin
          r = A_TGL;
        end
      end
    endcase
    return r;
  endfunction

  function automatic logic apply_act(input act_e a, input logic cur);
    logic n;
    case (a)
      A_CLR:   n = 1'b0;
      A_SET:   n = 1'b1;
      A_TGL:   n = ~cur;
      default: n = cur;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/wavecmp_regs.sv
module wavecmp_regs
  import wavecmp_pkg::*;
#(
  parameter int W   = 8,
  parameter int AW  = 3,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [W-1:0]            wr_data,
  input  logic                    ev_top,
  output logic [2:0]              mode,
  output logic [NCH-1:0][1:0]     code,
  output logic [NCH-1:0]          port_val,
  output logic [NCH-1:0]          dir,
  output logic [NCH-1:0][W-1:0]   act
);

  localparam logic [AW-1:0] AD_MODE = AW'(0);
  localparam logic [AW-1:0] AD_CODE = AW'(1);
  localparam logic [AW-1:0] AD_CMP0 = AW'(2);
  localparam logic [AW-1:0] AD_PIN  = AW'(2 + NCH);

  logic [NCH-1:0][W-1:0] cbuf;
  logic                  pwm;

  assign pwm = kind_pwm(mode_kind(mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= '0;
      code     <= '0;
      port_val <= '0;
      dir      <= '0;
    end else if (wr_en) begin
      if (wr_addr == AD_MODE) mode <= wr_data[2:0];
      if (wr_addr == AD_CODE) begin
        for (int i = 0; i < NCH; i++) code[i] <= wr_data[2*i +: 2];
      end
      if (wr_addr == AD_PIN) begin
        port_val <= wr_data[NCH-1:0];
        dir      <= wr_data[2*NCH-1:NCH];
      end
    end
  end

  // compare buffers and active compares, one pair per channel
  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    logic hit_wr;
    assign hit_wr = wr_en && (wr_addr == AD_CMP0 + AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cbuf[i] <= '0;
        act[i]  <= '0;
      end else begin
        if (hit_wr) cbuf[i] <= wr_data;
        if (pwm) begin
          if (ev_top) act[i] <= cbuf[i];
        end else if (hit_wr) begin
          act[i] <= wr_data;
        end
      end
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm && !ev_top) |=> $stable(act[i]));
    a_r10_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm && ev_top) |=> (act[i] == $past(cbuf[i])));
  end

endmodule

// File: rtl/wavecmp_counter.sv
module wavecmp_counter
  import wavecmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  kind_e        kind,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         ev_top
);

  localparam logic [W-1:0] ONE = W'(1);

  assign ev_top = tick && (cnt == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (tick) begin
      if (kind == K_PHASE) begin
        if (up) begin
          if (cnt == top) begin
            up  <= 1'b0;
            cnt <= (top == '0) ? '0 : cnt - ONE;
          end else begin
            cnt <= cnt + ONE;
          end
        end else begin
          if (cnt == '0) begin
            up  <= 1'b1;
            cnt <= (top == '0) ? '0 : cnt + ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
      end else begin
        up  <= 1'b1;
        cnt <= (cnt == top) ? '0 : cnt + ONE;
      end
    end
  end

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && kind != K_PHASE && cnt == top) |=> (cnt == '0));
  a_r3_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && kind == K_PHASE && up && cnt == top && top != '0) |=> !up);
  a_r11_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

endmodule

// File: rtl/wavecmp_channel.sv
module wavecmp_channel
  import wavecmp_pkg::*;
#(
  parameter int W    = 8,
  parameter bit IS_A = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  kind_e        kind,
  input  logic [1:0]   code,
  input  logic         hi_sel,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] act,
  input  logic [W-1:0] top,
  input  logic         ev_top,
  input  logic         up,
  output logic         wave,
  output logic         conn,
  output logic         ev_match
);

  logic eq_top;
  act_e nxt;

  assign ev_match = tick && (cnt == act);
  assign eq_top   = (act == top);
  assign conn     = chan_connected(kind, code, hi_sel, IS_A);

  always_comb nxt = chan_action(kind, code, hi_sel, IS_A, ev_match, ev_top, up, eq_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= apply_act(nxt, wave);
  end

  a_r11_wave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave));
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == K_NORM || kind == K_CTC) && code == 2'b01 && ev_match) |=> (wave != $past(wave)));
  a_r5_bottom_set: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_FAST && code == 2'b10 && ev_top) |=> wave);
  a_r7_up_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_PHASE && code == 2'b10 && up && ev_match && !(IS_A && eq_top)) |=> !wave);

  if (IS_A) begin : g_top_case
    a_r9_top_set: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_PHASE && code == 2'b10 && eq_top && ev_top) |=> wave);
  end

endmodule

// File: rtl/wavecmp_unit.sv
module wavecmp_unit
  import wavecmp_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [1:0]    pin_out,
  output logic [1:0]    pin_oe
);

  localparam int NCH = 2;

  logic [2:0]            mode;
  logic [NCH-1:0][1:0]   code;
  logic [NCH-1:0]        port_val;
  logic [NCH-1:0]        dir;
  logic [NCH-1:0][W-1:0] act;
  logic [NCH-1:0]        wave;
  logic [NCH-1:0]        conn;
  logic [NCH-1:0]        ev_match;
  kind_e                 kind;
  logic [W-1:0]          top;
  logic [W-1:0]          cnt;
  logic                  up;
  logic                  ev_top;

  assign kind = mode_kind(mode);
  assign top  = mode_top_cmp(mode) ? act[0] : '1;

  wavecmp_regs #(.W(W), .AW(AW), .NCH(NCH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ev_top   (ev_top),
    .mode     (mode),
    .code     (code),
    .port_val (port_val),
    .dir      (dir),
    .act      (act)
  );

  wavecmp_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .kind   (kind),
    .top    (top),
    .cnt    (cnt),
    .up     (up),
    .ev_top (ev_top)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wavecmp_channel #(.W(W), .IS_A(i == 0)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .kind     (kind),
      .code     (code[i]),
      .hi_sel   (mode[2]),
      .cnt      (cnt),
      .act      (act[i]),
      .top      (top),
      .ev_top   (ev_top),
      .up       (up),
      .wave     (wave[i]),
      .conn     (conn[i]),
      .ev_match (ev_match[i])
    );

    assign pin_oe[i]  = dir[i];
    assign pin_out[i] = dir[i] & (conn[i] ? wave[i] : port_val[i]);

    a_r2_quiet_pin: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[i] |-> !pin_out[i]);
  end

endmodule

// File: tb/wavecmp_unit_bench.sv
`timescale 1ns/1ps
module wavecmp_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] pin_out;
  logic [1:0] pin_oe;

  always #2 clk = ~clk;

  wavecmp_unit u_wavecmp_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [3:0] q_exp[$];
  string      q_req[$];
  logic [1:0] seen_out;

  // reference state
  logic [7:0] m_cnt, m_act0, m_act1, m_buf0, m_buf1;
  logic       m_up;
  logic [1:0] m_wave, m_port, m_dir;
  logic [2:0] m_mode;
  logic [1:0] m_code0, m_code1;

  task automatic model_reset();
    m_cnt = 0; m_up = 1; m_act0 = 0; m_act1 = 0; m_buf0 = 0; m_buf1 = 0;
    m_wave = 0; m_port = 0; m_dir = 0; m_mode = 0; m_code0 = 0; m_code1 = 0;
  endtask

  function automatic bit is_pwm(logic [2:0] m);
    return m == 3'b011 || m == 3'b111 || m == 3'b001 || m == 3'b101;
  endfunction

  function automatic bit is_phase(logic [2:0] m);
    return m == 3'b001 || m == 3'b101;
  endfunction

  function automatic logic next_wave(int c, logic cur, logic [1:0] cd, logic [7:0] cmpv,
                                     logic [7:0] topv);
    logic nw;
    bit hit, tp, inv;
    nw = cur; hit = (m_cnt == cmpv); tp = (m_cnt == topv); inv = (cd == 2'd3);
    if (!is_pwm(m_mode)) begin
      if (hit) begin
        if (cd == 2'd1) nw = ~cur;
        else if (cd == 2'd2) nw = 1'b0;
        else if (cd == 2'd3) nw = 1'b1;
      end
    end else if (cd == 2'd1) begin
      if (c == 0 && m_mode[2] && hit) nw = ~cur;
    end else if (cd >= 2'd2) begin
      if (c == 0 && m_act0 == topv) begin
        if (tp) nw = !inv;
      end else if (!is_phase(m_mode)) begin
        if (tp) nw = !inv;
        else if (hit) nw = inv;
      end else if (hit) begin
        nw = m_up ? inv : !inv;
      end
    end
    return nw;
  endfunction

  function automatic bit linked(int c, logic [1:0] cd);
    if (cd == 2'd0) return 1'b0;
    if (is_pwm(m_mode) && cd == 2'd1) return (c == 0) && m_mode[2];
    return 1'b1;
  endfunction

  task automatic model_step(bit t, bit we, logic [2:0] a, logic [7:0] d, output logic [3:0] ex);
    logic [7:0] topv;
    logic w0, w1;
    bit pw, ph, attop;
    pw = is_pwm(m_mode); ph = is_phase(m_mode);
    topv = (m_mode == 3'b010 || m_mode == 3'b111 || m_mode == 3'b101) ? m_act0 : 8'hFF;
    attop = (m_cnt == topv);
    if (t) begin
      w0 = next_wave(0, m_wave[0], m_code0, m_act0, topv);
      w1 = next_wave(1, m_wave[1], m_code1, m_act1, topv);
      m_wave = {w1, w0};
      if (pw && attop) begin m_act0 = m_buf0; m_act1 = m_buf1; end
      if (ph) begin
        if (m_up) begin
          if (attop) begin m_up = 0; m_cnt = (topv == 0) ? 8'd0 : m_cnt - 8'd1; end
          else m_cnt = m_cnt + 8'd1;
        end else begin
          if (m_cnt == 0) begin m_up = 1; m_cnt = (topv == 0) ? 8'd0 : 8'd1; end
          else m_cnt = m_cnt - 8'd1;
        end
      end else begin
        m_up = 1;
        m_cnt = attop ? 8'd0 : m_cnt + 8'd1;
      end
    end
    if (we) begin
      case (a)
        3'd0: m_mode = d[2:0];
        3'd1: begin m_code0 = d[1:0]; m_code1 = d[3:2]; end
        3'd2: begin m_buf0 = d; if (!pw) m_act0 = d; end
        3'd3: begin m_buf1 = d; if (!pw) m_act1 = d; end
        3'd4: begin m_port = d[1:0]; m_dir = d[3:2]; end
        default: ;
      endcase
    end
    ex[2] = m_dir[0]; ex[3] = m_dir[1];
    ex[0] = m_dir[0] & (linked(0, m_code0) ? m_wave[0] : m_port[0]);
    ex[1] = m_dir[1] & (linked(1, m_code1) ? m_wave[1] : m_port[1]);
  endtask

  task automatic drive(bit t, bit we, logic [2:0] a, logic [7:0] d, string req);
    logic [3:0] ex;
    @(negedge clk);
    seen_out = pin_out;
    tick = t; wr_en = we; wr_addr = a; wr_data = d;
    model_step(t, we, a, d, ex);
    q_exp.push_back(ex);
    q_req.push_back(req);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string req);
    drive(1'b0, 1'b1, a, d, req);
  endtask

  task automatic run(int n, string req);
    for (int k = 0; k < n; k++) drive(1'b1, 1'b0, 3'd0, 8'd0, req);
  endtask

  task automatic idle(int n, string req);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 3'd0, 8'd0, req);
  endtask

  task automatic count_high(int n, int ch, string req, int want);
    int hi;
    hi = 0;
    for (int k = 0; k < n; k++) begin
      drive(1'b1, 1'b0, 3'd0, 8'd0, req);
      hi += int'(seen_out[ch]);
    end
    n_chk++;
    if (hi != want) begin
      n_bad++;
      $display("FAIL %s: high samples got %0d expected %0d", req, hi, want);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    tick = 0; wr_en = 0; rst_n = 0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    n_chk++;
    if (pin_out !== 2'b00 || pin_oe !== 2'b00) begin
      n_bad++;
      $display("FAIL R1: got out=%b oe=%b expected out=00 oe=00", pin_out, pin_oe);
    end
  endtask

  // monitor: compares the design against the predicted pins after each edge
  always @(posedge clk) begin
    logic [3:0] e;
    string r;
    #1;
    if (rst_n && q_exp.size() != 0) begin
      e = q_exp.pop_front();
      r = q_req.pop_front();
      n_chk++;
      if ({pin_oe, pin_out} !== e) begin
        n_bad++;
        $display("FAIL %s: got oe/out=%b expected %b", r, {pin_oe, pin_out}, e);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();                                         // R1
    // R2: pin mux with port values and direction bits
    wr(3'd4, 8'h05, "R2"); idle(2, "R2");
    wr(3'd4, 8'h0E, "R2"); idle(2, "R2");

    // R4: normal mode, every action code
    do_reset();
    wr(3'd2, 8'd5, "R4"); wr(3'd3, 8'd10, "R4"); wr(3'd4, 8'h0C, "R4");
    wr(3'd1, 8'b1101, "R4"); run(600, "R4");
    wr(3'd1, 8'b0110, "R4"); run(300, "R4");

    // R3: restart-on-compare mode
    do_reset();
    wr(3'd2, 8'd20, "R3"); wr(3'd3, 8'd7, "R3"); wr(3'd4, 8'h0C, "R3");
    wr(3'd1, 8'b1001, "R3"); wr(3'd0, 8'd2, "R3"); run(100, "R3");
    wr(3'd1, 8'h0F, "R4"); run(60, "R4");

    // R12: reserved mode codes run as normal
    do_reset();
    wr(3'd2, 8'd3, "R12"); wr(3'd3, 8'd200, "R12"); wr(3'd4, 8'h0C, "R12");
    wr(3'd1, 8'h05, "R12"); wr(3'd0, 8'd4, "R12"); run(300, "R12");
    wr(3'd0, 8'd6, "R12"); run(300, "R12");

    // R5: fast PWM, fixed TOP, inverting A and non-inverting B
    do_reset();
    wr(3'd2, 8'd100, "R5"); wr(3'd3, 8'd50, "R5"); wr(3'd4, 8'h0C, "R5");
    wr(3'd1, 8'b1011, "R5"); wr(3'd0, 8'd3, "R5"); run(600, "R5");
    // R5: TOP 9, compare B 3, non-inverting: 4 high ticks of 10
    do_reset();
    wr(3'd2, 8'd9, "R5"); wr(3'd3, 8'd3, "R5"); wr(3'd4, 8'h0C, "R5");
    wr(3'd1, 8'b1000, "R5"); wr(3'd0, 8'd7, "R5"); run(25, "R5");
    count_high(10, 1, "R5", 4);

    // R6: channel B code 01 reserved in PWM modes shows port value
    do_reset();
    wr(3'd2, 8'd40, "R6"); wr(3'd3, 8'd20, "R6"); wr(3'd4, 8'h0E, "R6");
    wr(3'd1, 8'b0100, "R6"); wr(3'd0, 8'd3, "R6"); run(100, "R6");
    count_high(30, 1, "R6", 30);
    wr(3'd0, 8'd1, "R6"); run(100, "R6");

    // R8: channel A code 01 in PWM modes
    do_reset();
    wr(3'd2, 8'd6, "R8"); wr(3'd4, 8'h0D, "R8"); wr(3'd1, 8'h01, "R8");
    wr(3'd0, 8'd3, "R8"); run(300, "R8");
    wr(3'd0, 8'd7, "R8"); run(50, "R8");
    wr(3'd0, 8'd1, "R8"); run(520, "R8");
    wr(3'd0, 8'd5, "R8"); run(60, "R8");

    // R7: phase-correct, direction-dependent actions
    do_reset();
    wr(3'd2, 8'd60, "R7"); wr(3'd3, 8'd200, "R7"); wr(3'd4, 8'h0C, "R7");
    wr(3'd1, 8'b1110, "R7"); wr(3'd0, 8'd1, "R7"); run(1100, "R7");
    wr(3'd1, 8'b1011, "R7"); run(600, "R7");
    do_reset();
    wr(3'd2, 8'd30, "R7"); wr(3'd3, 8'd12, "R7"); wr(3'd4, 8'h0C, "R7");
    wr(3'd1, 8'b1000, "R7"); wr(3'd0, 8'd5, "R7"); run(200, "R7");

    // R9: compare A at TOP
    do_reset();
    wr(3'd2, 8'hFF, "R9"); wr(3'd4, 8'h0C, "R9"); wr(3'd1, 8'h02, "R9");
    wr(3'd0, 8'd1, "R9"); run(600, "R9");
    count_high(40, 0, "R9", 40);
    wr(3'd1, 8'h03, "R9"); run(600, "R9");
    do_reset();
    wr(3'd2, 8'd9, "R9"); wr(3'd4, 8'h0C, "R9"); wr(3'd1, 8'h02, "R9");
    wr(3'd0, 8'd7, "R9"); run(40, "R9");
    count_high(20, 0, "R9", 20);
    wr(3'd1, 8'h03, "R9"); run(40, "R9");
    count_high(20, 0, "R9", 0);

    // R10: buffered compares in PWM, immediate otherwise
    do_reset();
    wr(3'd2, 8'd9, "R10"); wr(3'd3, 8'd2, "R10"); wr(3'd4, 8'h0C, "R10");
    wr(3'd1, 8'b1000, "R10"); wr(3'd0, 8'd7, "R10"); run(23, "R10");
    wr(3'd3, 8'd7, "R10"); run(30, "R10");
    wr(3'd2, 8'd15, "R10"); run(40, "R10");
    wr(3'd0, 8'd0, "R10"); wr(3'd3, 8'd100, "R10"); run(120, "R10");
    wr(3'd3, 8'd30, "R10"); run(300, "R10");

    // R11: nothing moves without a tick
    do_reset();
    wr(3'd2, 8'd4, "R11"); wr(3'd3, 8'd4, "R11"); wr(3'd4, 8'h0C, "R11");
    wr(3'd1, 8'h05, "R11"); run(5, "R11"); idle(10, "R11");
    run(3, "R11"); idle(5, "R11"); run(300, "R11");

    idle(3, "R11");
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule